// File: doc/BRIEF.md
# Pixel Lookup Table Loader

This block remaps every pixel on a display path through a 256-entry, 8-bit lookup table. The host reaches the table indirectly. It first writes an entry number to an index register. It then writes the new value to a value register, and that write stores the value at the indexed entry. Two control registers decide whether the table may be changed. A value write lands only when the load-permit bit is set and the stored-image-view bit is clear. A value write under any other setting is dropped without a trace.

The pixel stream passes through a single registered lookup stage. Each incoming pixel is used as the table address. The entry it selects appears one clock later, together with a valid flag. While the blanking bit is set, every pixel leaves as black (zero), and a blanking flag travels with the stream. This lets the host hide the display while it rewrites the table. After reset the table is the identity map, so the picture passes through unchanged until the host loads something else.

Top module: `pix_lut_top`

## Requirements
- R1: After reset the table holds the identity map (entry i = i). All control bits and the index register are zero. `pix_valid_out`, `pix_out` and `blank_out` are zero.
- R2: Host writes use `reg_sel` as follows: 0 = control 0, 1 = control 1, 2 = index, 3 = value. A permitted value write stores `reg_wdata` in the entry named by the index register.
- R3: A value write changes the table only when control-1 bit 0 (load permit) is 1 and control-0 bit 2 (stored-image view) is 0.
- R4: A value write under any other control setting leaves every table entry unchanged. Writes to other registers also leave the table unchanged.
- R5: The index register does not advance on value writes. Successive value writes all go to the last index written.
- R6: A pixel presented with `pix_valid_in` high appears as its table entry on `pix_out` exactly one cycle later, with `pix_valid_out` high. Back-to-back pixels stream at one per cycle.
- R7: While control-1 bit 1 (blank) is set, accepted pixels leave as 0, and `blank_out` is 1 one cycle after the bit is set.
- R8: A pixel looked up in the same cycle as a value write to its entry sees the old entry. A pixel looked up in the next cycle sees the new entry.
- R9: When `pix_valid_in` is low, `pix_valid_out` goes low one cycle later and `pix_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 ctrl0, 1 ctrl1, 2 index, 3 value |
| reg_wdata | input | 8 | Host write data |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_in | input | 8 | Input pixel, used as the table address |
| pix_valid_out | output | 1 | Output pixel valid, one cycle after input |
| pix_out | output | 8 | Remapped or blanked pixel |
| blank_out | output | 1 | Blanking in force, aligned with the output stage |

## Verification
A corrupted table entry shows up only when a pixel of that value passes through. It then appears one cycle after that pixel, which is why the bench sweeps all 256 codes after a full reload. A wrong index or a wrongly opened write gate changes an entry the host never meant to touch. Probing both the intended entry and its neighbour exposes this on the next lookup. A stale blank bit or a misaligned valid flag is visible on the very next output cycle.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL0 = 2'd0,
    SEL_CTRL1 = 2'd1,
    SEL_INDEX = 2'd2,
    SEL_VALUE = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int VIEW_BIT  = 2;  // ctrl0: stored-image view
  localparam int LOAD_BIT  = 0;  // ctrl1: load permit
  localparam int BLANK_BIT = 1;  // ctrl1: blank display

endpackage

// File: rtl/lut_host_regs.sv
module lut_host_regs
  import pix_lut_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] idx_q,
  output logic             tbl_we,
  output logic [PIX_W-1:0] tbl_wdata,
  output logic             blank_q
);

  logic             view_q, load_q;
  logic             view_nxt, load_nxt, blank_nxt;
  logic [PIX_W-1:0] idx_nxt;
  logic             ctrl0_en, ctrl1_en, idx_en;

  always_comb begin
    ctrl0_en  = wr_en && (sel == SEL_CTRL0);
    ctrl1_en  = wr_en && (sel == SEL_CTRL1);
    idx_en    = wr_en && (sel == SEL_INDEX);
    view_nxt  = ctrl0_en ? wdata[VIEW_BIT]  : view_q;
    load_nxt  = ctrl1_en ? wdata[LOAD_BIT]  : load_q;
    blank_nxt = ctrl1_en ? wdata[BLANK_BIT] : blank_q;
    idx_nxt   = idx_en   ? wdata            : idx_q;
  end

  // gate: value writes land only with load permitted and stored view off
  always_comb begin
    tbl_we    = wr_en && (sel == SEL_VALUE) && load_q && !view_q;
    tbl_wdata = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_q  <= 1'b0;
      load_q  <= 1'b0;
      blank_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      view_q  <= view_nxt;
      load_q  <= load_nxt;
      blank_q <= blank_nxt;
      idx_q   <= idx_nxt;
    end
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_INDEX) |=> $stable(idx_q)); // R5

endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PIX_W-1:0] waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [PIX_W-1:0] raddr,
  output logic [PIX_W-1:0] rdata
);

  localparam int ENTRIES = 1 << PIX_W;

  logic [ENTRIES-1:0][PIX_W-1:0] tbl_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic             hit;
    logic [PIX_W-1:0] ent_nxt;

    always_comb begin
      hit     = we && (waddr == PIX_W'(e));
      ent_nxt = hit ? wdata : tbl_q[e];
    end

    // reset value is the entry's own number: identity map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_q[e] <= PIX_W'(e);
      else        tbl_q[e] <= ent_nxt;
    end
  end

  assign rdata = tbl_q[raddr];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tbl_q[$past(waddr)] == $past(wdata)); // R2

  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(tbl_q)); // R4

endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [PIX_W-1:0] lut_val,
  input  logic             blank,
  output logic             valid_out,
  output logic [PIX_W-1:0] pix_out,
  output logic             blank_out
);

  logic             valid_q, blank_q;
  logic [PIX_W-1:0] pix_q, pix_nxt;

  always_comb begin
    if (valid_in) pix_nxt = blank ? '0 : lut_val;
    else          pix_nxt = pix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blank_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= valid_in;
      blank_q <= blank;
      pix_q   <= pix_nxt;
    end
  end

  assign valid_out = valid_q;
  assign pix_out   = pix_q;
  assign blank_out = blank_q;

  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out == $past(valid_in)); // R6

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && blank) |=> (pix_out == '0 && blank_out)); // R7

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(pix_out)); // R9

endmodule

// File: rtl/pix_lut_top.sv
module pix_lut_top
  import pix_lut_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [PIX_W-1:0] reg_wdata,
  input  logic             pix_valid_in,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_valid_out,
  output logic [PIX_W-1:0] pix_out,
  output logic             blank_out
);

  logic             rst_meta, rst_sync;
  logic [PIX_W-1:0] idx_q, tbl_wdata, lut_val;
  logic             tbl_we, blank_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  lut_host_regs #(.PIX_W(PIX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .wr_en     (reg_wr_en),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .idx_q     (idx_q),
    .tbl_we    (tbl_we),
    .tbl_wdata (tbl_wdata),
    .blank_q   (blank_q)
  );

  lut_table #(.PIX_W(PIX_W)) u_table (
    .clk   (clk),
    .rst_n (rst_sync),
    .we    (tbl_we),
    .waddr (idx_q),
    .wdata (tbl_wdata),
    .raddr (pix_in),
    .rdata (lut_val)
  );

  lut_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync),
    .valid_in  (pix_valid_in),
    .lut_val   (lut_val),
    .blank     (blank_q),
    .valid_out (pix_valid_out),
    .pix_out   (pix_out),
    .blank_out (blank_out)
  );

endmodule

// File: tb/sim_pix_lut_top.sv
`timescale 1ns/1ps
module sim_pix_lut_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic       pix_valid_in;
  logic [7:0] pix_in;
  logic       pix_valid_out;
  logic [7:0] pix_out;
  logic       blank_out;

  always #2 clk = ~clk;  // 250 MHz

  pix_lut_top #(.PIX_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pix_valid_in(pix_valid_in), .pix_in(pix_in),
    .pix_valid_out(pix_valid_out), .pix_out(pix_out), .blank_out(blank_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  // bench model built from the requirements
  logic [7:0] m_tbl [256];
  logic [7:0] m_idx;
  logic       m_view, m_load, m_blank;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (sel)
      2'd0: m_view = d[2];
      2'd1: begin m_load = d[0]; m_blank = d[1]; end
      2'd2: m_idx = d;
      default: if (m_load && !m_view) m_tbl[m_idx] = d;
    endcase
  endtask

  function automatic logic [7:0] expect_pix(input logic [7:0] p);
    return m_blank ? 8'h00 : m_tbl[p];
  endfunction

  task automatic probe(input logic [7:0] p, input string tag);
    @(negedge clk);
    pix_valid_in = 1'b1; pix_in = p;
    @(negedge clk);
    pix_valid_in = 1'b0;
    check(pix_valid_out, 1, {tag, " valid"});
    check(pix_out, expect_pix(p), tag);
  endtask

  task automatic t_reset();
    check(pix_valid_out, 0, "R1 valid_out after reset");
    check(pix_out, 0, "R1 pix_out after reset");
    check(blank_out, 0, "R1 blank_out after reset");
    probe(8'd0,   "R1 identity entry 0");
    probe(8'd5,   "R1 identity entry 5");
    probe(8'd255, "R1 identity entry 255");
  endtask

  task automatic t_gate();
    write_reg(2'd2, 8'd10);
    write_reg(2'd3, 8'h55);            // load off: dropped
    probe(8'd10, "R4 write without load permit ignored");
    write_reg(2'd1, 8'h01);
    write_reg(2'd0, 8'h04);            // stored view on
    write_reg(2'd3, 8'h66);            // dropped
    probe(8'd10, "R3 write with view on ignored");
    write_reg(2'd0, 8'h00);
    write_reg(2'd1, 8'h03);            // load + blank
    write_reg(2'd3, 8'h55);
    probe(8'd10, "R7 blanked pixel is black");
    check(blank_out, 1, "R7 blank_out set");
    write_reg(2'd1, 8'h01);
    probe(8'd10, "R2 value landed at index 10");
    check(blank_out, 0, "R7 blank_out clear");
    probe(8'd11, "R4 neighbour entry 11 untouched");
  endtask

  task automatic t_no_incr();
    write_reg(2'd2, 8'd20);
    write_reg(2'd3, 8'hA1);
    write_reg(2'd3, 8'hB2);
    probe(8'd20, "R5 second write overwrote same entry");
    probe(8'd21, "R5 next entry not advanced into");
  endtask

  task automatic t_same_cycle();
    write_reg(2'd2, 8'd40);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd3; reg_wdata = 8'h3C;
    pix_valid_in = 1'b1; pix_in = 8'd40;
    @(negedge clk);
    reg_wr_en = 1'b0; pix_valid_in = 1'b0;
    check(pix_out, m_tbl[40], "R8 same-cycle lookup sees old entry");
    m_tbl[40] = 8'h3C;
    probe(8'd40, "R8 next lookup sees new entry");
  endtask

  task automatic t_reload_stream();
    for (int i = 0; i < 256; i++) begin
      write_reg(2'd2, 8'(i));
      write_reg(2'd3, 8'(i * 7 + 3));
    end
    write_reg(2'd1, 8'h00);
    for (int k = 0; k <= 256; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(pix_valid_out, 1, "R6 stream valid");
        check(pix_out, m_tbl[(k - 1) ^ 8'hA5], "R6 stream remap");
      end
      pix_valid_in = (k < 256);
      pix_in = 8'(k ^ 8'hA5);
    end
    pix_valid_in = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] last;
    probe(8'd77, "R6 single lookup");
    last = pix_out;
    @(negedge clk);
    check(pix_valid_out, 0, "R9 valid drops");
    pix_in = 8'd3;
    @(negedge clk);
    @(negedge clk);
    check(pix_out, last, "R9 output held while idle");
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    pix_valid_in = 1'b0; pix_in = 8'h00;
    for (int i = 0; i < 256; i++) m_tbl[i] = 8'(i);
    m_idx = 8'h00; m_view = 1'b0; m_load = 1'b0; m_blank = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gate();
    t_no_incr();
    t_same_cycle();
    t_reload_stream();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule